// File: doc/BRIEF.md
# Timestamping Address-Event Monitor

This block watches a four-phase request/acknowledge address-event bus and records every completed transaction as a group of self-identifying 18-bit words on a FIFO write port. The request and acknowledge lines pass through a two-flop synchroniser. The address is latched when the synchronised acknowledge rises. An event counts as complete when the synchronised acknowledge falls while the synchronised request is already low. At that moment the block samples a free-running 32-bit time value supplied from outside.

Each word carries a 2-bit type tag above a 16-bit payload. A reader that loses its place in the stream can therefore find its way back by inspecting the tags. When two or four senders share the bus, the sender number sits in the top address bits, and a per-sender ignore mask drops the traffic of selected senders. An active-low run input gates all acquisition. A time-label enable chooses between one word per event and three words per event. When the FIFO is full at the start of an event, the whole event is dropped and a sticky overflow flag is set, so the stream never holds a partial group.

Top module: `aer_evt_monitor`

## Requirements
- R1: Every written word is 18 bits. Bits 17:16 hold the type tag and bits 15:0 hold the payload.
- R2: The tag values are 00 for the event address, 01 for timestamp bits 31:16 and 10 for timestamp bits 15:0. The block never writes tag 11.
- R3: With the time label enabled, an accepted event writes three words on three consecutive cycles: address, time-high, time-low. The cycle after time-low carries no write.
- R4: With the time label disabled, an accepted event writes only its address word.
- R5: The timestamp is `time_i` as sampled on the third rising clock edge after `ack_i` falls. Later changes of `time_i` do not alter it.
- R6: The address is `addr_i` as latched when the synchronised acknowledge rises. Changes of `addr_i` after `ack_i` falls do not alter it.
- R7: The sender number is derived from the address according to `sender_cfg_i`. With 00 (one sender) it is 0. With 01 (two senders) it is address bit 15. With 10 or 11 (four senders) it is address bits 15:14. If `ch_ignore_i[sender]` is 1, the event writes nothing and leaves the overflow flag unchanged.
- R8: While `run_ni` is 1, events write nothing.
- R9: If `fifo_full_i` is 1 on the cycle an accepted event would start, the event writes no word and `overflow_o` goes to 1. It then stays at 1 until reset. A full indication that appears after the address word has been written does not truncate the group.
- R10: An accepted event that arrives while an earlier group is still being written is dropped and sets `overflow_o`. The earlier group completes intact.
- R11: During and directly after reset there are no writes and `overflow_o` is 0.
- R12: Detection uses the synchronised acknowledge falling while the synchronised request is low. The address word appears in the cycle after the fourth rising edge following the fall of `ack_i`. An acknowledge that falls while request is still high is not an event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus request (asynchronous) |
| ack_i | input | 1 | Bus acknowledge (asynchronous) |
| addr_i | input | 16 | Event address |
| time_i | input | 32 | Free-running time value |
| sender_cfg_i | input | 2 | Sender count: 00 one, 01 two, 1x four |
| ch_ignore_i | input | 4 | Per-sender ignore mask (1 = drop) |
| time_en_i | input | 1 | Write timestamp words when 1 |
| run_ni | input | 1 | Acquisition enable, active low |
| fifo_full_i | input | 1 | FIFO full indication |
| fifo_wr_o | output | 1 | FIFO write strobe |
| fifo_data_o | output | 18 | Tagged FIFO word |
| overflow_o | output | 1 | Sticky dropped-event flag |

## Verification
The assertions assume that the address is held stable from the rise of request until after acknowledge has risen and been synchronised. They also assume that configuration inputs do not change while an event is being detected. The time-high/time-low ordering checks rely on the sequencer never being restarted in the middle of a group. The stimulus honours these assumptions by driving every handshake phase for several clocks and by changing configuration and the full flag only between events. The one exception is the deliberate mid-group full pulse. For the busy-drop case the bench issues a second acknowledge pulse of one clock on purpose.

// File: rtl/aer_mon_pkg.sv
package aer_mon_pkg;
  typedef enum logic [1:0] {
    TAG_ADDR = 2'b00,
    TAG_THI  = 2'b01,
    TAG_TLO  = 2'b10,
    TAG_CTRL = 2'b11
  } tag_e;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_ADDR,
    SEQ_THI,
    SEQ_TLO
  } seq_st_e;
endpackage

// File: rtl/aer_mon_sync.sv
module aer_mon_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < STAGES; k++) st_q[k] <= '0;
    end else begin
      st_q[0] <= d_i;
      for (int k = 1; k < STAGES; k++) st_q[k] <= st_q[k-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/aer_mon_detect.sv
module aer_mon_detect #(
  parameter int ADDR_W = 16,
  parameter int TIME_W = 32,
  parameter int NUM_CH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_s_i,
  input  logic              ack_s_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [TIME_W-1:0] time_i,
  input  logic [1:0]        sender_cfg_i,
  input  logic [NUM_CH-1:0] ch_ignore_i,
  input  logic              time_en_i,
  input  logic              run_ni,
  output logic              evt_o,
  output logic [ADDR_W-1:0] evt_addr_o,
  output logic [TIME_W-1:0] evt_time_o,
  output logic              evt_ten_o
);
  localparam int CH_W = $clog2(NUM_CH);

  logic              ack_d_q;
  logic [ADDR_W-1:0] cap_addr_q;
  logic              ack_rise, ack_fall, keep;
  logic [CH_W-1:0]   ch;

  assign ack_rise = ack_s_i & ~ack_d_q;
  // completed handshake: request already withdrawn when acknowledge drops
  assign ack_fall = ~ack_s_i & ack_d_q & ~req_s_i;

  always_comb begin
    unique case (sender_cfg_i)
      2'b00:   ch = '0;
      2'b01:   ch = CH_W'(cap_addr_q[ADDR_W-1]);
      default: ch = cap_addr_q[ADDR_W-1 -: CH_W];
    endcase
  end

  assign keep = ~run_ni & ~ch_ignore_i[ch];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_d_q    <= 1'b0;
      cap_addr_q <= '0;
      evt_o      <= 1'b0;
      evt_addr_o <= '0;
      evt_time_o <= '0;
      evt_ten_o  <= 1'b0;
    end else begin
      ack_d_q <= ack_s_i;
      if (ack_rise) cap_addr_q <= addr_i;
      evt_o <= ack_fall & keep;
      if (ack_fall) begin
        evt_addr_o <= cap_addr_q;
        evt_time_o <= time_i;
        evt_ten_o  <= time_en_i;
      end
    end
  end
endmodule

// File: rtl/aer_mon_seq.sv
module aer_mon_seq
  import aer_mon_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int TIME_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              evt_i,
  input  logic [ADDR_W-1:0] evt_addr_i,
  input  logic [TIME_W-1:0] evt_time_i,
  input  logic              evt_ten_i,
  input  logic              fifo_full_i,
  output logic              wr_o,
  output logic [ADDR_W+1:0] data_o,
  output logic              ovf_o
);
  localparam int HALF = TIME_W / 2;

  seq_st_e           st_q;
  logic [ADDR_W-1:0] addr_q;
  logic [TIME_W-1:0] time_q;
  logic              ten_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= SEQ_IDLE;
      addr_q <= '0;
      time_q <= '0;
      ten_q  <= 1'b0;
      ovf_o  <= 1'b0;
    end else begin
      unique case (st_q)
        SEQ_IDLE: if (evt_i) begin
          if (fifo_full_i) ovf_o <= 1'b1;   // drop whole group
          else begin
            addr_q <= evt_addr_i;
            time_q <= evt_time_i;
            ten_q  <= evt_ten_i;
            st_q   <= SEQ_ADDR;
          end
        end
        SEQ_ADDR: st_q <= ten_q ? SEQ_THI : SEQ_IDLE;
        SEQ_THI:  st_q <= SEQ_TLO;
        default:  st_q <= SEQ_IDLE;
      endcase
      if (st_q != SEQ_IDLE && evt_i) ovf_o <= 1'b1;  // busy drop
    end
  end

  always_comb begin
    wr_o = (st_q != SEQ_IDLE);
    unique case (st_q)
      SEQ_THI: data_o = {TAG_THI, ADDR_W'(time_q[TIME_W-1 -: HALF])};
      SEQ_TLO: data_o = {TAG_TLO, ADDR_W'(time_q[HALF-1:0])};
      default: data_o = {TAG_ADDR, addr_q};
    endcase
  end
endmodule

// File: rtl/aer_evt_monitor.sv
module aer_evt_monitor #(
  parameter int ADDR_W      = 16,
  parameter int TIME_W      = 32,
  parameter int NUM_CH      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              ack_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [TIME_W-1:0] time_i,
  input  logic [1:0]        sender_cfg_i,
  input  logic [NUM_CH-1:0] ch_ignore_i,
  input  logic              time_en_i,
  input  logic              run_ni,
  input  logic              fifo_full_i,
  output logic              fifo_wr_o,
  output logic [ADDR_W+1:0] fifo_data_o,
  output logic              overflow_o
);
  logic [1:0]        hs_s;
  logic              evt;
  logic [ADDR_W-1:0] evt_addr;
  logic [TIME_W-1:0] evt_time;
  logic              evt_ten;

  aer_mon_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i({req_i, ack_i}), .q_o(hs_s)
  );

  aer_mon_detect #(.ADDR_W(ADDR_W), .TIME_W(TIME_W), .NUM_CH(NUM_CH)) u_det (
    .clk_i, .rst_ni,
    .req_s_i(hs_s[1]), .ack_s_i(hs_s[0]),
    .addr_i, .time_i, .sender_cfg_i, .ch_ignore_i, .time_en_i, .run_ni,
    .evt_o(evt), .evt_addr_o(evt_addr), .evt_time_o(evt_time), .evt_ten_o(evt_ten)
  );

  aer_mon_seq #(.ADDR_W(ADDR_W), .TIME_W(TIME_W)) u_seq (
    .clk_i, .rst_ni,
    .evt_i(evt), .evt_addr_i(evt_addr), .evt_time_i(evt_time), .evt_ten_i(evt_ten),
    .fifo_full_i, .wr_o(fifo_wr_o), .data_o(fifo_data_o), .ovf_o(overflow_o)
  );
endmodule

// File: rtl/aer_mon_chk.sv
module aer_mon_chk #(
  parameter int DATA_W = 18
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              fifo_full_i,
  input logic              fifo_wr_o,
  input logic [DATA_W-1:0] fifo_data_o,
  input logic              overflow_o
);
  logic [1:0] tag;
  assign tag = fifo_data_o[DATA_W-1 -: 2];

  // R2
  no_ctrl_tag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_wr_o |-> tag != 2'b11);
  // R3
  thi_after_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_wr_o && tag == 2'b01) |-> $past(fifo_wr_o && tag == 2'b00));
  // R3
  tlo_after_thi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_wr_o && tag == 2'b01) |=> (fifo_wr_o && tag == 2'b10));
  // R3
  gap_after_tlo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_wr_o && tag == 2'b10) |=> !fifo_wr_o);
  // R9
  no_start_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_wr_o && tag == 2'b00) |-> !$past(fifo_full_i));
  // R9
  overflow_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);
  // R11
  reset_quiet_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (!fifo_wr_o && !overflow_o));
endmodule

bind aer_evt_monitor aer_mon_chk #(.DATA_W(ADDR_W + 2)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .fifo_full_i(fifo_full_i),
  .fifo_wr_o(fifo_wr_o), .fifo_data_o(fifo_data_o), .overflow_o(overflow_o)
);

// File: tb/tb_aer_evt_monitor.sv
`timescale 1ns/1ps
module tb_aer_evt_monitor;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 0, ack_i = 0;
  logic [15:0] addr_i = '0;
  logic [31:0] time_i = '0;
  logic [1:0]  sender_cfg_i = 2'b00;
  logic [3:0]  ch_ignore_i = '0;
  logic        time_en_i = 1'b1;
  logic        run_ni = 1'b0;
  logic        fifo_full_i = 1'b0;
  logic        fifo_wr_o;
  logic [17:0] fifo_data_o;
  logic        overflow_o;

  int n_cmp = 0, n_bad = 0;
  bit ovf_model = 0;

  always #4 clk = ~clk;

  aer_evt_monitor dut (
    .clk_i(clk), .rst_ni, .req_i, .ack_i, .addr_i, .time_i, .sender_cfg_i,
    .ch_ignore_i, .time_en_i, .run_ni, .fifo_full_i,
    .fifo_wr_o, .fifo_data_o, .overflow_o
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int sender_of(logic [15:0] a, logic [1:0] m);
    if (m == 2'b00) return 0;
    if (m == 2'b01) return int'(a[15]);
    return int'(a[15:14]);
  endfunction

  function automatic logic [17:0] exp_word(int k, logic [15:0] a, logic [31:0] t);
    if (k == 0) return {2'b00, a};
    if (k == 1) return {2'b01, t[31:16]};
    return {2'b10, t[15:0]};
  endfunction

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    // R11
    chk(!fifo_wr_o && !overflow_o, "R11 reset state", {fifo_wr_o, overflow_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(!fifo_wr_o && !overflow_o, "R11 after reset", {fifo_wr_o, overflow_o}, 0);
    ovf_model = 0;
  endtask

  task automatic send(input logic [15:0] a, input logic [31:0] t,
                      input bit full_mid, input bit bad_order);
    logic [17:0] got [8];
    int  n_got = 0, first = -1, n_exp;
    bit  keep, full_start;
    string lbl;
    keep = !run_ni && !ch_ignore_i[sender_of(a, sender_cfg_i)] && !bad_order;
    full_start = fifo_full_i;
    n_exp = (keep && !full_start) ? (time_en_i ? 3 : 1) : 0;
    if (keep && full_start) ovf_model = 1;
    if (bad_order) lbl = "R12";
    else if (run_ni) lbl = "R8";
    else if (!keep) lbl = "R7";
    else if (full_start) lbl = "R9";
    else if (time_en_i) lbl = "R3";
    else lbl = "R4";

    @(negedge clk); addr_i = a; time_i = t; req_i = 1;
    repeat (2) @(negedge clk); ack_i = 1;
    repeat (4) @(negedge clk); if (!bad_order) req_i = 0;
    repeat (4) @(negedge clk); ack_i = 0; addr_i = 16'($urandom);  // R6: late change
    repeat (3) @(posedge clk);
    #1 time_i = $urandom;                                        // R5: late change
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (fifo_wr_o) begin
        if (first < 0) first = i;
        if (n_got < 8) got[n_got] = fifo_data_o;
        n_got++;
      end
      if (full_mid && i == 1) fifo_full_i = 1'b1;
    end
    if (bad_order) req_i = 0;
    fifo_full_i = full_start;
    repeat (4) @(negedge clk);

    chk(n_got == n_exp, lbl, n_got, n_exp);
    if (n_got == n_exp) begin
      for (int k = 0; k < n_exp; k++)
        chk(got[k] == exp_word(k, a, t), "R1 R2 R5 R6 word", got[k], exp_word(k, a, t));
    end
    if (n_exp > 0) chk(first == 1, "R12 latency", first, 1);
    chk(overflow_o == ovf_model, "R9 overflow", overflow_o, ovf_model);
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    do_reset();

    // directed: both time modes, one sender
    send(16'h26FE, 32'h0001_0000, 0, 0);
    time_en_i = 0;
    send(16'hF433, 32'hDEAD_BEEF, 0, 0);
    time_en_i = 1;

    // R8 stopped acquisition
    run_ni = 1;
    send(16'h1234, 32'h1111_2222, 0, 0);
    run_ni = 0;

    // R7 four senders, ignore sender 2 (bits 15:14 = 10)
    sender_cfg_i = 2'b10; ch_ignore_i = 4'b0100;
    send(16'h8055, 32'h3333_4444, 0, 0);
    send(16'hC055, 32'h5555_6666, 0, 0);
    // two senders, bit 15 selects: ignore sender 1
    sender_cfg_i = 2'b01; ch_ignore_i = 4'b0010;
    send(16'h8001, 32'h7777_8888, 0, 0);
    send(16'h4001, 32'h9999_AAAA, 0, 0);
    sender_cfg_i = 2'b00; ch_ignore_i = 4'b0000;

    // R12 ack released while request still high
    send(16'h0BAD, 32'h0, 0, 1);

    // R9 full mid-group does not truncate
    send(16'h3344, 32'hCAFE_F00D, 1, 0);

    // random events
    for (int n = 0; n < 40; n++) begin
      sender_cfg_i = 2'($urandom);
      ch_ignore_i  = 4'($urandom_range(0, 15) & 4'($urandom));
      time_en_i    = 1'($urandom);
      run_ni       = ($urandom_range(0, 7) == 0);
      send(16'($urandom), $urandom, 0, 0);
    end
    sender_cfg_i = 2'b00; ch_ignore_i = '0; run_ni = 0; time_en_i = 1;

    // R9 full at start: dropped, overflow sticky
    fifo_full_i = 1;
    send(16'h75E2, 32'h0102_0304, 0, 0);
    fifo_full_i = 0;
    send(16'h75E3, 32'h0506_0708, 0, 0);
    chk(overflow_o == 1'b1, "R9 sticky", overflow_o, 1);
    do_reset();

    // R10 second event while first group is being written
    begin
      logic [17:0] got [8];
      int n_got = 0;
      @(negedge clk); addr_i = 16'hA5A5; time_i = 32'h1357_9BDF; req_i = 1;
      repeat (2) @(negedge clk); ack_i = 1;
      repeat (4) @(negedge clk); req_i = 0;
      repeat (4) @(negedge clk); ack_i = 0;
      @(negedge clk); ack_i = 1;
      @(negedge clk); ack_i = 0;
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        if (fifo_wr_o) begin
          if (n_got < 8) got[n_got] = fifo_data_o;
          n_got++;
        end
      end
      chk(n_got == 3, "R10 count", n_got, 3);
      if (n_got == 3)
        for (int k = 0; k < 3; k++)
          chk(got[k] == exp_word(k, 16'hA5A5, 32'h1357_9BDF), "R10 word",
              got[k], exp_word(k, 16'hA5A5, 32'h1357_9BDF));
      chk(overflow_o == 1'b1, "R10 overflow", overflow_o, 1);
    end
    do_reset();

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule